// File: doc/BRIEF.md
# NAND Access Width Adapter

This block sits between a host register port and an external NAND-style flash device. It turns one host access of 1, 2 or 4 bytes into a series of bus cycles at the device's own width, which is 8 or 16 bits. A configuration bit selects the width. The number of device cycles therefore depends on both the access size and the device width. Bytes always go out least-significant first. Read data is put back together little-endian and returned to the host in one word.

The host chooses one of three access windows: command, address or data. A write to the command window drives the command-latch strobe, a write to the address window drives the address-latch strobe, and a data access drives neither. Each device cycle holds its strobe until the device acknowledges it. Chip enable stays asserted across every cycle of one access. When the attached device is not a NAND part, the block makes no device cycle and still completes the host access. A read in that case returns zero.

Top module: `nand_width_adapter`

## Requirements
- R1: With `cfg_width[0]`=0 (8-bit device), size code 0 makes one device cycle, code 1 makes two, and code 2 makes four. Code 3 behaves as code 2.
- R2: On an 8-bit device, byte k of the access uses device cycle k, counting from the least-significant byte. Write byte k is driven on `dev_dout[7:0]` with `dev_dout[15:8]`=0. Read cycle k fills `rsp_rdata[8k+7:8k]`, and any bytes not read are 0.
- R3: With `cfg_width[0]`=1 (16-bit device), size code 1 makes one device cycle carrying bits 15:0. Size code 2 makes two cycles: bits 15:0 first, then bits 31:16. Read halves land at the same positions.
- R4: A 1-byte read from a 16-bit device makes one device read and returns `dev_din[7:0]`, with `rsp_rdata[31:8]`=0.
- R5: A 1-byte write to a 16-bit device is carried out as one cycle that drives the full `req_wdata[15:0]`.
- R6: `req_window` selects the latch strobes: code 0 is command, 1 is address, 2 and 3 are data. A write to the command window raises only `dev_cle`, a write to the address window raises only `dev_ale`, and data writes and all reads raise neither. The latch strobes appear only together with `dev_we`.
- R7: Only `cfg_width[0]` selects the device width. `cfg_width[1]` has no effect.
- R8: With `cfg_is_nand`=0, an access makes no device cycle (`dev_ce` stays low), `req_ready` still pulses, and `rsp_rdata` is 0.
- R9: `dev_we` or `dev_re` stays high, with `dev_dout` stable, until a cycle with `dev_ack`=1. `req_ready` is high for exactly one cycle, only after the last acknowledged device cycle, and is never high while a device cycle is active.
- R10: `dev_ce` stays high from the first device cycle to the last. Between two cycles of one access, the strobes drop for one clock while `dev_ce` stays high. `dev_ce` is low in the `req_ready` cycle.
- R11: After reset, `req_ready`, `dev_ce`, `dev_cle`, `dev_ale`, `dev_we`, `dev_re`, `dev_dout` and `rsp_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_is_nand | input | 1 | 1 when the attached device is a NAND part |
| cfg_width | input | 2 | Device width field; bit 0: 0 = 8-bit, 1 = 16-bit; bit 1 ignored |
| req_valid | input | 1 | Host access request; fields held until req_ready |
| req_ready | output | 1 | One-cycle completion pulse; rsp_rdata valid with it |
| req_write | input | 1 | 1 = write, 0 = read |
| req_window | input | 2 | 0 command, 1 address, 2/3 data |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| req_wdata | input | 32 | Host write data |
| rsp_rdata | output | 32 | Assembled read data |
| dev_ce | output | 1 | Device chip enable |
| dev_cle | output | 1 | Command-latch strobe |
| dev_ale | output | 1 | Address-latch strobe |
| dev_we | output | 1 | Write cycle strobe |
| dev_re | output | 1 | Read cycle strobe |
| dev_dout | output | 16 | Data to the device |
| dev_din | input | 16 | Data from the device |
| dev_ack | input | 1 | Device completes the current cycle |

## Verification
The bench uses the default widths: a 32-bit host word and a 16-bit device bus. With these widths every size code can be combined with both device widths, so the 1-, 2- and 4-cycle cases and both truncation corner cases are all reachable. The device model in the bench can hold off its acknowledge for several cycles. This exposes a strobe that drops early or a completion that arrives before the last acknowledge. Runs with the non-NAND flag set and with the ignored width bit set check that the block has no side effects in those cases.

// File: rtl/nwa_pkg.sv
// Shared encodings for the NAND access width adapter.
package nwa_pkg;
    typedef enum logic [1:0] {
        WIN_CMD  = 2'd0,
        WIN_ADDR = 2'd1,
        WIN_DATA = 2'd2,
        WIN_ALT  = 2'd3
    } win_e;

    typedef enum logic [1:0] {
        SZ_ONE  = 2'd0,
        SZ_TWO  = 2'd1,
        SZ_FOUR = 2'd2,
        SZ_WIDE = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_STROBE,
        SEQ_GAP,
        SEQ_DONE
    } seq_e;
endpackage

// File: rtl/nwa_plan.sv
// nwa_plan: decodes one host request into a device-cycle count and its
// latch and truncation flags. Purely combinational; it assumes the request
// fields are stable while req_valid is high.
module nwa_plan #(
    parameter int BEAT_W = 3
) (
    input  logic [1:0]        size,
    input  logic [1:0]        window,
    input  logic              write,
    input  logic              wide,
    input  logic              is_nand,
    output logic [BEAT_W-1:0] beats,
    output logic              trunc,
    output logic              cle_sel,
    output logic              ale_sel,
    output logic              skip
);
    import nwa_pkg::*;

    size_e size_v;
    win_e  win_v;

    assign size_v = size_e'(size);
    assign win_v  = win_e'(window);

    // Cycle count from access size and device width
    always_comb begin
        case (size_v)
            SZ_ONE:  beats = BEAT_W'(1);
            SZ_TWO:  beats = wide ? BEAT_W'(1) : BEAT_W'(2);
            default: beats = wide ? BEAT_W'(2) : BEAT_W'(4);
        endcase
    end

    // Latch strobe selection and special cases
    always_comb begin
        trunc   = wide && !write && (size_v == SZ_ONE);
        cle_sel = write && (win_v == WIN_CMD);
        ale_sel = write && (win_v == WIN_ADDR);
        skip    = !is_nand;
    end
endmodule

// File: rtl/nwa_seq.sv
// nwa_seq: sequences the device cycles of one access. Each cycle holds its
// strobe until an acknowledge, and an idle gap separates two cycles. The
// access ends with a one-cycle done state. Assumes beats >= 1.
module nwa_seq #(
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              skip,
    input  logic [BEAT_W-1:0] beats,
    input  logic              dev_ack,
    output logic              accept,
    output logic              capture,
    output logic              strobe_on,
    output logic              ce_on,
    output logic              done,
    output logic [BEAT_W-1:0] idx
);
    import nwa_pkg::*;

    seq_e              state_q;
    logic [BEAT_W-1:0] total_q;
    logic              last_beat;

    assign last_beat = (idx + BEAT_W'(1)) == total_q;

    // Handshake outputs decoded from state
    always_comb begin
        accept    = (state_q == SEQ_IDLE) && req_valid;
        strobe_on = (state_q == SEQ_STROBE);
        capture   = strobe_on && dev_ack;
        ce_on     = (state_q == SEQ_STROBE) || (state_q == SEQ_GAP);
        done      = (state_q == SEQ_DONE);
    end

    // State, beat index and beat total
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            idx     <= '0;
            total_q <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: if (req_valid) begin
                    idx     <= '0;
                    total_q <= beats;
                    state_q <= skip ? SEQ_DONE : SEQ_STROBE;
                end
                SEQ_STROBE: if (dev_ack) begin
                    if (last_beat) begin
                        state_q <= SEQ_DONE;
                    end else begin
                        idx     <= idx + BEAT_W'(1);
                        state_q <= SEQ_GAP;
                    end
                end
                SEQ_GAP:  state_q <= SEQ_STROBE;
                default:  state_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nwa_lane.sv
// nwa_lane: selects the write slice for the current device cycle and
// collects read slices into the host word, least-significant first.
// Assumes DEV_W is 16 and HOST_W is a multiple of DEV_W.
module nwa_lane #(
    parameter int HOST_W = 32,
    parameter int DEV_W  = 16,
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic              wide,
    input  logic              trunc,
    input  logic [BEAT_W-1:0] idx,
    input  logic [HOST_W-1:0] wdata,
    input  logic [DEV_W-1:0]  din,
    output logic [DEV_W-1:0]  dout,
    output logic [HOST_W-1:0] rdata
);
    localparam int NARROW_W = DEV_W / 2;
    localparam int BYTES    = HOST_W / 8;
    localparam int PER_HALF = DEV_W / 8;

    // Write slice for the current beat, narrow slices zero-extended
    always_comb begin
        if (wide) begin
            dout = wdata[int'(idx) * DEV_W +: DEV_W];
        end else begin
            dout = {{(DEV_W - NARROW_W){1'b0}}, wdata[int'(idx) * NARROW_W +: NARROW_W]};
        end
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        localparam int HALF = g / PER_HALF;
        localparam int SUB  = g % PER_HALF;
        logic [7:0] lane_q;

        // Capture this byte from the beat that carries it
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                lane_q <= '0;
            end else if (capture) begin
                if (!wide) begin
                    if (int'(idx) == g) lane_q <= din[7:0];
                end else if (int'(idx) == HALF && !(trunc && SUB != 0)) begin
                    lane_q <= din[SUB * 8 +: 8];
                end
            end
        end

        assign rdata[g * 8 +: 8] = lane_q;
    end
endmodule

// File: rtl/nand_width_adapter.sv
// nand_width_adapter: serialises a 1/2/4-byte host access into 8- or
// 16-bit device cycles, with latch strobes picked by the target window.
// Assumes the request fields and configuration stay stable from accept
// until req_ready.
module nand_width_adapter #(
    parameter int HOST_W = 32,
    parameter int DEV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_is_nand,
    input  logic [1:0]        cfg_width,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_window,
    input  logic [1:0]        req_size,
    input  logic [HOST_W-1:0] req_wdata,
    output logic [HOST_W-1:0] rsp_rdata,
    output logic              dev_ce,
    output logic              dev_cle,
    output logic              dev_ale,
    output logic              dev_we,
    output logic              dev_re,
    output logic [DEV_W-1:0]  dev_dout,
    input  logic [DEV_W-1:0]  dev_din,
    input  logic              dev_ack
);
    localparam int MAX_BEATS = HOST_W / 8;
    localparam int BEAT_W    = $clog2(MAX_BEATS + 1);

    logic              width_hi_unused;
    logic [BEAT_W-1:0] plan_beats;
    logic              plan_trunc, plan_cle, plan_ale, plan_skip;
    logic              accept, capture, strobe_on, ce_on, done;
    logic [BEAT_W-1:0] idx;
    logic              wr_q, cle_q, ale_q, wide_q, trunc_q;
    logic [HOST_W-1:0] wdata_q;
    logic [DEV_W-1:0]  lane_dout;

    assign width_hi_unused = cfg_width[1];

    nwa_plan #(.BEAT_W(BEAT_W)) i_plan (
        .size    (req_size),
        .window  (req_window),
        .write   (req_write),
        .wide    (cfg_width[0]),
        .is_nand (cfg_is_nand),
        .beats   (plan_beats),
        .trunc   (plan_trunc),
        .cle_sel (plan_cle),
        .ale_sel (plan_ale),
        .skip    (plan_skip)
    );

    nwa_seq #(.BEAT_W(BEAT_W)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .skip      (plan_skip),
        .beats     (plan_beats),
        .dev_ack   (dev_ack),
        .accept    (accept),
        .capture   (capture),
        .strobe_on (strobe_on),
        .ce_on     (ce_on),
        .done      (done),
        .idx       (idx)
    );

    // Hold the access attributes for the whole access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            cle_q   <= 1'b0;
            ale_q   <= 1'b0;
            wide_q  <= 1'b0;
            trunc_q <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            cle_q   <= plan_cle;
            ale_q   <= plan_ale;
            wide_q  <= cfg_width[0];
            trunc_q <= plan_trunc;
            wdata_q <= req_wdata;
        end
    end

    nwa_lane #(.HOST_W(HOST_W), .DEV_W(DEV_W), .BEAT_W(BEAT_W)) i_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture (capture && !wr_q),
        .wide    (wide_q),
        .trunc   (trunc_q),
        .idx     (idx),
        .wdata   (wdata_q),
        .din     (dev_din),
        .dout    (lane_dout),
        .rdata   (rsp_rdata)
    );

    // Device-side strobes and data drive
    always_comb begin
        req_ready = done;
        dev_ce    = ce_on;
        dev_we    = strobe_on && wr_q;
        dev_re    = strobe_on && !wr_q;
        dev_cle   = strobe_on && cle_q;
        dev_ale   = strobe_on && ale_q;
        dev_dout  = (strobe_on && wr_q) ? lane_dout : '0;
    end
endmodule

// File: rtl/nwa_checker.sv
// nwa_checker: protocol properties of the adapter, bound to the top module.
module nwa_checker #(
    parameter int DEV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             cfg_is_nand,
    input logic             dev_ce,
    input logic             dev_cle,
    input logic             dev_ale,
    input logic             dev_we,
    input logic             dev_re,
    input logic             dev_ack,
    input logic [DEV_W-1:0] dev_dout
);
    assert_latch_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dev_cle, dev_ale}));

    assert_latch_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_cle || dev_ale) |-> dev_we);

    assert_dir_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_we && dev_re));

    assert_hold_until_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((dev_we || dev_re) && !dev_ack) |=> ((dev_we || dev_re) && $stable(dev_dout)));

    assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(dev_ce || dev_we || dev_re));

    assert_strobe_in_ce_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_we || dev_re) |-> dev_ce);

    assert_ce_until_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_ce) |-> req_ready);

    assert_no_cycle_off_nand_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_ce) |-> $past(cfg_is_nand));
endmodule

bind nand_width_adapter nwa_checker #(.DEV_W(DEV_W)) i_nwa_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .cfg_is_nand (cfg_is_nand),
    .dev_ce      (dev_ce),
    .dev_cle     (dev_cle),
    .dev_ale     (dev_ale),
    .dev_we      (dev_we),
    .dev_re      (dev_re),
    .dev_ack     (dev_ack),
    .dev_dout    (dev_dout)
);

// File: tb/test_nand_width_adapter.sv
// Scoreboard bench: the driver queues expected device cycles, and the device
// model pops and compares each one as the adapter produces it.
module test_nand_width_adapter;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wr;
        logic        cle;
        logic        ale;
        logic [15:0] dout;
        logic [15:0] rdv;
    } beat_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_is_nand = 1'b1;
    logic [1:0]  cfg_width = 2'b00;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_window = 2'd2;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        dev_ce, dev_cle, dev_ale, dev_we, dev_re;
    logic [15:0] dev_dout;
    logic [15:0] dev_din = '0;
    logic        dev_ack = 1'b0;

    int    checks = 0;
    int    failures = 0;
    int    stall_cfg = 0;
    bit    finished = 0;
    beat_t exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    nand_width_adapter i_nand_width_adapter (
        .clk(clk), .rst_n(rst_n), .cfg_is_nand(cfg_is_nand), .cfg_width(cfg_width),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_window(req_window), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .dev_ce(dev_ce), .dev_cle(dev_cle), .dev_ale(dev_ale),
        .dev_we(dev_we), .dev_re(dev_re), .dev_dout(dev_dout), .dev_din(dev_din),
        .dev_ack(dev_ack)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Device model and monitor: compares each device cycle with the queue
    initial begin
        int stall_left = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) continue;
            if (dev_ack) begin
                dev_ack = 1'b0;
                continue;
            end
            if (dev_we || dev_re) begin
                if (stall_left < stall_cfg) begin
                    stall_left++;
                    chk("R9", "ready during held cycle", {31'b0, req_ready}, 32'd0);
                    continue;
                end
                stall_left = 0;
                if (exp_q.size() == 0) begin
                    chk("R8", "unexpected device cycle", 32'd1, 32'd0);
                    dev_ack = 1'b1;
                end else begin
                    beat_t b;
                    string t;
                    b = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(t, "we/re/cle/ale/ce",
                        {27'b0, dev_we, dev_re, dev_cle, dev_ale, dev_ce},
                        {27'b0, b.wr, !b.wr, b.cle, b.ale, 1'b1});
                    chk(t, "dev_dout", {16'b0, dev_dout}, {16'b0, b.dout});
                    dev_din = b.rdv;
                    dev_ack = 1'b1;
                end
            end
        end
    end

    // Driver: queues the expected cycles, runs one access, checks the result
    task automatic access(input string tag, input logic wr, input logic [1:0] win,
                          input logic [1:0] size, input logic [31:0] wdata,
                          input logic [1:0] width, input logic nand_on,
                          input logic [15:0] rbase);
        int          n;
        bit          wide;
        bit          got;
        logic [31:0] exp_rd;
        wide   = width[0];
        exp_rd = '0;
        if (!nand_on) n = 0;
        else if (size == 2'd0) n = 1;
        else if (size == 2'd1) n = wide ? 1 : 2;
        else n = wide ? 2 : 4;
        for (int i = 0; i < n; i++) begin
            beat_t b;
            b.wr   = wr;
            b.cle  = wr && (win == 2'd0);
            b.ale  = wr && (win == 2'd1);
            b.rdv  = rbase + 16'(i * 16'h1357);
            if (!wr) b.dout = '0;
            else if (wide) b.dout = wdata[i*16 +: 16];
            else b.dout = {8'h00, wdata[i*8 +: 8]};
            if (!wr) begin
                if (!wide) exp_rd[i*8 +: 8] = b.rdv[7:0];
                else if (size == 2'd0) exp_rd[7:0] = b.rdv[7:0];
                else exp_rd[i*16 +: 16] = b.rdv;
            end
            exp_q.push_back(b);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        cfg_width   = width;
        cfg_is_nand = nand_on;
        req_write   = wr;
        req_window  = win;
        req_size    = size;
        req_wdata   = wdata;
        req_valid   = 1'b1;
        got = 0;
        for (int w = 0; w < 2000; w++) begin
            @(negedge clk);
            if (req_ready) begin
                got = 1;
                break;
            end
        end
        chk(tag, "ready seen", {31'b0, got}, 32'd1);
        if (!wr) chk(tag, "rsp_rdata", rsp_rdata, exp_rd);
        req_valid = 1'b0;
        chk(tag, "cycles left", exp_q.size(), 32'd0);
        exp_q.delete();
        tag_q.delete();
        @(negedge clk);
        chk("R9", "ready one cycle", {31'b0, req_ready}, 32'd0);
        chk("R10", "ce after access", {31'b0, dev_ce}, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11", "outputs in reset",
            {25'b0, req_ready, dev_ce, dev_cle, dev_ale, dev_we, dev_re, 1'b0}, 32'd0);
        chk("R11", "dout/rdata in reset", {16'b0, dev_dout} | rsp_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R2: narrow writes and reads
        access("R1", 1'b1, 2'd2, 2'd0, 32'hA1B2C3D4, 2'b00, 1'b1, 16'h0011);
        access("R1", 1'b1, 2'd2, 2'd1, 32'h11223344, 2'b00, 1'b1, 16'h0011);
        access("R2", 1'b1, 2'd2, 2'd2, 32'hDEADBEEF, 2'b00, 1'b1, 16'h0011);
        access("R1", 1'b1, 2'd2, 2'd3, 32'h0F1E2D3C, 2'b00, 1'b1, 16'h0011);
        access("R2", 1'b0, 2'd2, 2'd0, 32'h0, 2'b00, 1'b1, 16'h12A5);
        access("R2", 1'b0, 2'd2, 2'd1, 32'h0, 2'b00, 1'b1, 16'h3C96);
        access("R2", 1'b0, 2'd2, 2'd2, 32'h0, 2'b00, 1'b1, 16'hF00D);
        // R3: wide accesses
        access("R3", 1'b1, 2'd2, 2'd1, 32'h5555ABCD, 2'b01, 1'b1, 16'h0);
        access("R3", 1'b1, 2'd2, 2'd2, 32'h89ABCDEF, 2'b01, 1'b1, 16'h0);
        access("R3", 1'b0, 2'd2, 2'd2, 32'h0, 2'b01, 1'b1, 16'hBEEF);
        access("R3", 1'b0, 2'd3, 2'd1, 32'h0, 2'b01, 1'b1, 16'h7A5C);
        // R4, R5: 1-byte on a wide device
        access("R4", 1'b0, 2'd2, 2'd0, 32'h0, 2'b01, 1'b1, 16'hC3E7);
        access("R5", 1'b1, 2'd2, 2'd0, 32'hABCD1234, 2'b01, 1'b1, 16'h0);
        // R6: windows
        access("R6", 1'b1, 2'd0, 2'd0, 32'h000000FF, 2'b00, 1'b1, 16'h0);
        access("R6", 1'b1, 2'd1, 2'd2, 32'h00A0B0C0, 2'b01, 1'b1, 16'h0);
        access("R6", 1'b1, 2'd1, 2'd2, 32'h04030201, 2'b00, 1'b1, 16'h0);
        access("R6", 1'b0, 2'd0, 2'd1, 32'h0, 2'b00, 1'b1, 16'h6161);
        access("R6", 1'b0, 2'd1, 2'd0, 32'h0, 2'b01, 1'b1, 16'h9E9E);
        // R7: upper width bit ignored
        access("R7", 1'b1, 2'd2, 2'd2, 32'hCAFEF00D, 2'b10, 1'b1, 16'h0);
        access("R7", 1'b0, 2'd2, 2'd2, 32'h0, 2'b11, 1'b1, 16'h4321);
        // R8: non-NAND device
        access("R8", 1'b0, 2'd2, 2'd2, 32'h0, 2'b00, 1'b0, 16'hFFFF);
        access("R8", 1'b1, 2'd0, 2'd2, 32'h12345678, 2'b01, 1'b0, 16'h0);
        // R9, R10: slow acknowledges
        stall_cfg = 3;
        access("R9", 1'b1, 2'd1, 2'd2, 32'h76543210, 2'b00, 1'b1, 16'h0);
        access("R10", 1'b0, 2'd2, 2'd2, 32'h0, 2'b01, 1'b1, 16'h2468);
        access("R9", 1'b0, 2'd2, 2'd2, 32'h0, 2'b00, 1'b1, 16'h0F0F);
        stall_cfg = 0;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule